// File: doc/BRIEF.md
# Multi-Ported VLIW Register File

This block is the shared general register file of a four-slot wide-issue core. Each instruction slot drives a functional unit: two ALUs, a memory unit and a control unit. Every instruction cycle the register file serves eight independent reads: two source operands for each ALU, the store-data and index operands of the memory unit, and the test and index operands of the control unit. In the same cycle it accepts up to four writes: one destination per ALU, the load destination of the memory unit, and the link destination of the control unit on a call.

Read data comes combinationally from the register state captured at the most recent clock edge. Every read in a cycle therefore returns the value that stood before that cycle's writes. A result written by one instruction becomes visible to every unit at the next instruction, and no path carries it into the same cycle. When more than one unit targets the same register in the same cycle, a fixed ranking selects the one that lands. A synchronous reset clears the whole file.

All ports are plain register-file ports with no handshake. A read is always valid, and a write is taken whenever its enable is high. The block never applies back-pressure.

Top module: `vliw_regfile`

## Requirements
- R1: The file holds 64 registers selected by a 6-bit address, and each of the eight read ports returns the register at its own address independently of the others; two read ports given the same address return identical data.
- R2: Read data is combinational from the register state latched at the last rising clock edge; a read of a register that is being written in the same cycle returns the old value, and the new value appears only after that edge.
- R3: A write port whose enable is high at a rising edge stores its data into the register at its address, provided no higher-ranked port targets the same register.
- R4: A write port whose enable is low changes no register, whatever its address and data inputs carry.
- R5: When several enabled write ports target one register in the same cycle, exactly one value is stored, chosen by rank from highest to lowest: memory load, control link, ALU b, ALU a.
- R6: While the synchronous reset is high at a rising edge, every register becomes zero regardless of any write enable; after reset, every read returns zero until written.
- R7: Enabled write ports that target four different registers all commit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears every register |
| alua_rs0_addr | input | 6 | ALU a first source register |
| alua_rs0_data | output | 32 | ALU a first source value |
| alua_rs1_addr | input | 6 | ALU a second source register |
| alua_rs1_data | output | 32 | ALU a second source value |
| alub_rs0_addr | input | 6 | ALU b first source register |
| alub_rs0_data | output | 32 | ALU b first source value |
| alub_rs1_addr | input | 6 | ALU b second source register |
| alub_rs1_data | output | 32 | ALU b second source value |
| mem_sd_addr | input | 6 | Memory unit store-data register |
| mem_sd_data | output | 32 | Memory unit store-data value |
| mem_ix_addr | input | 6 | Memory unit index register |
| mem_ix_data | output | 32 | Memory unit index value |
| ctl_tst_addr | input | 6 | Control unit test register |
| ctl_tst_data | output | 32 | Control unit test value |
| ctl_ix_addr | input | 6 | Control unit index register |
| ctl_ix_data | output | 32 | Control unit index value |
| alua_wr_en | input | 1 | ALU a destination write enable |
| alua_wr_addr | input | 6 | ALU a destination register |
| alua_wr_data | input | 32 | ALU a result |
| alub_wr_en | input | 1 | ALU b destination write enable |
| alub_wr_addr | input | 6 | ALU b destination register |
| alub_wr_data | input | 32 | ALU b result |
| mem_wr_en | input | 1 | Memory load write enable |
| mem_wr_addr | input | 6 | Memory load destination register |
| mem_wr_data | input | 32 | Loaded value |
| ctl_wr_en | input | 1 | Control link write enable |
| ctl_wr_addr | input | 6 | Control link destination register |
| ctl_wr_data | input | 32 | Link value |

## Verification
Two pairs of functions meet in one cycle: a read and a write to the same register, and two or more writes to the same register. The bench provokes the first by pointing read ports at the write addresses of the current cycle. It provokes the second by driving all four write ports, or chosen subsets of them, at one address, and by running a random phase whose addresses come from a narrow range of eight registers. A behavioural model applies the writes in rank order after each edge. The bench compares all eight read outputs with the model on every cycle, before the edge, which judges old-value visibility and the winning rank together.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int unsigned NUM_WR = 4;
  localparam int unsigned NUM_RD = 8;

  // Write port index doubles as rank: a higher index wins a collision.
  typedef enum logic [1:0] {
    WP_ALUA = 2'd0,
    WP_ALUB = 2'd1,
    WP_CTRL = 2'd2,
    WP_MEM  = 2'd3
  } wport_e;

  // Read port slots in the order the top module packs them.
  typedef enum logic [2:0] {
    RP_ALUA0 = 3'd0,
    RP_ALUA1 = 3'd1,
    RP_ALUB0 = 3'd2,
    RP_ALUB1 = 3'd3,
    RP_MEMSD = 3'd4,
    RP_MEMIX = 3'd5,
    RP_CTLTS = 3'd6,
    RP_CTLIX = 3'd7
  } rport_e;
endpackage

// File: rtl/vrf_write_select.sv
// Per-register write steering: resolves the four write ports into a single
// enable and data word for one entry, ranked by port index.
module vrf_write_select
  import vrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned ENTRY  = 0
) (
  input  logic [NUM_WR-1:0]             wr_en,
  input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data,
  output logic                          hit,
  output logic [DATA_W-1:0]             hit_data
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ENTRY);

  logic [NUM_WR-1:0] match;

  always_comb begin
    for (int p = 0; p < NUM_WR; p++) begin
      match[p] = wr_en[p] && (wr_addr[p] == MY_ADDR);
    end
  end

  // Walk from lowest to highest rank; the last match overrides.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      if (match[p]) begin
        hit      = 1'b1;
        hit_data = wr_data[p];
      end
    end
  end
endmodule

// File: rtl/vrf_storage.sv
// Register array with a per-entry load strobe and synchronous clear.
module vrf_storage #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DEPTH-1:0]              ld,
  input  logic [DEPTH-1:0][DATA_W-1:0]  ld_data,
  output logic [DEPTH-1:0][DATA_W-1:0]  q
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        q[e] <= '0;
      end else if (ld[e]) begin
        q[e] <= ld_data[e];
      end
    end
  end
endmodule

// File: rtl/vrf_read_port.sv
// One combinational read port over the latched array.
module vrf_read_port #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] q,
  input  logic [ADDR_W-1:0]            addr,
  output logic [DATA_W-1:0]            data
);
  always_comb begin
    data = q[addr];
  end
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile
  import vrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] alua_rs0_addr,
  output logic [DATA_W-1:0] alua_rs0_data,
  input  logic [ADDR_W-1:0] alua_rs1_addr,
  output logic [DATA_W-1:0] alua_rs1_data,
  input  logic [ADDR_W-1:0] alub_rs0_addr,
  output logic [DATA_W-1:0] alub_rs0_data,
  input  logic [ADDR_W-1:0] alub_rs1_addr,
  output logic [DATA_W-1:0] alub_rs1_data,
  input  logic [ADDR_W-1:0] mem_sd_addr,
  output logic [DATA_W-1:0] mem_sd_data,
  input  logic [ADDR_W-1:0] mem_ix_addr,
  output logic [DATA_W-1:0] mem_ix_data,
  input  logic [ADDR_W-1:0] ctl_tst_addr,
  output logic [DATA_W-1:0] ctl_tst_data,
  input  logic [ADDR_W-1:0] ctl_ix_addr,
  output logic [DATA_W-1:0] ctl_ix_data,
  input  logic              alua_wr_en,
  input  logic [ADDR_W-1:0] alua_wr_addr,
  input  logic [DATA_W-1:0] alua_wr_data,
  input  logic              alub_wr_en,
  input  logic [ADDR_W-1:0] alub_wr_addr,
  input  logic [DATA_W-1:0] alub_wr_data,
  input  logic              mem_wr_en,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  input  logic [DATA_W-1:0] mem_wr_data,
  input  logic              ctl_wr_en,
  input  logic [ADDR_W-1:0] ctl_wr_addr,
  input  logic [DATA_W-1:0] ctl_wr_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [NUM_WR-1:0]             wp_en;
  logic [NUM_WR-1:0][ADDR_W-1:0] wp_addr;
  logic [NUM_WR-1:0][DATA_W-1:0] wp_data;

  logic [NUM_RD-1:0][ADDR_W-1:0] rp_addr;
  logic [NUM_RD-1:0][DATA_W-1:0] rp_data;

  logic [DEPTH-1:0]              ent_ld;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_data;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_q;

  // Pack write ports by rank.
  always_comb begin
    wp_en[WP_ALUA]   = alua_wr_en;
    wp_addr[WP_ALUA] = alua_wr_addr;
    wp_data[WP_ALUA] = alua_wr_data;
    wp_en[WP_ALUB]   = alub_wr_en;
    wp_addr[WP_ALUB] = alub_wr_addr;
    wp_data[WP_ALUB] = alub_wr_data;
    wp_en[WP_CTRL]   = ctl_wr_en;
    wp_addr[WP_CTRL] = ctl_wr_addr;
    wp_data[WP_CTRL] = ctl_wr_data;
    wp_en[WP_MEM]    = mem_wr_en;
    wp_addr[WP_MEM]  = mem_wr_addr;
    wp_data[WP_MEM]  = mem_wr_data;
  end

  // Pack read addresses by slot.
  always_comb begin
    rp_addr[RP_ALUA0] = alua_rs0_addr;
    rp_addr[RP_ALUA1] = alua_rs1_addr;
    rp_addr[RP_ALUB0] = alub_rs0_addr;
    rp_addr[RP_ALUB1] = alub_rs1_addr;
    rp_addr[RP_MEMSD] = mem_sd_addr;
    rp_addr[RP_MEMIX] = mem_ix_addr;
    rp_addr[RP_CTLTS] = ctl_tst_addr;
    rp_addr[RP_CTLIX] = ctl_ix_addr;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_wsel
    vrf_write_select #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .ENTRY  (e)
    ) u_wsel (
      .wr_en    (wp_en),
      .wr_addr  (wp_addr),
      .wr_data  (wp_data),
      .hit      (ent_ld[e]),
      .hit_data (ent_data[e])
    );
  end

  vrf_storage #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .ld      (ent_ld),
    .ld_data (ent_data),
    .q       (ent_q)
  );

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    vrf_read_port #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_rd (
      .q    (ent_q),
      .addr (rp_addr[r]),
      .data (rp_data[r])
    );
  end

  assign alua_rs0_data = rp_data[RP_ALUA0];
  assign alua_rs1_data = rp_data[RP_ALUA1];
  assign alub_rs0_data = rp_data[RP_ALUB0];
  assign alub_rs1_data = rp_data[RP_ALUB1];
  assign mem_sd_data   = rp_data[RP_MEMSD];
  assign mem_ix_data   = rp_data[RP_MEMIX];
  assign ctl_tst_data  = rp_data[RP_CTLTS];
  assign ctl_ix_data   = rp_data[RP_CTLIX];
endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] alua_rs0_addr,
  input logic [DATA_W-1:0] alua_rs0_data,
  input logic [ADDR_W-1:0] alua_rs1_addr,
  input logic [DATA_W-1:0] alua_rs1_data,
  input logic [ADDR_W-1:0] alub_rs0_addr,
  input logic [DATA_W-1:0] alub_rs0_data,
  input logic [ADDR_W-1:0] alub_rs1_addr,
  input logic [DATA_W-1:0] alub_rs1_data,
  input logic [ADDR_W-1:0] mem_sd_addr,
  input logic [DATA_W-1:0] mem_sd_data,
  input logic [ADDR_W-1:0] mem_ix_addr,
  input logic [DATA_W-1:0] mem_ix_data,
  input logic [ADDR_W-1:0] ctl_tst_addr,
  input logic [DATA_W-1:0] ctl_tst_data,
  input logic [ADDR_W-1:0] ctl_ix_addr,
  input logic [DATA_W-1:0] ctl_ix_data,
  input logic              alua_wr_en,
  input logic [ADDR_W-1:0] alua_wr_addr,
  input logic [DATA_W-1:0] alua_wr_data,
  input logic              alub_wr_en,
  input logic [ADDR_W-1:0] alub_wr_addr,
  input logic [DATA_W-1:0] alub_wr_data,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              ctl_wr_en,
  input logic [ADDR_W-1:0] ctl_wr_addr,
  input logic [DATA_W-1:0] ctl_wr_data
);
  logic any_wr;
  logic ctl_beats_mem;
  logic alua_alone;

  assign any_wr        = alua_wr_en | alub_wr_en | mem_wr_en | ctl_wr_en;
  assign ctl_beats_mem = ctl_wr_en && !(mem_wr_en && mem_wr_addr == ctl_wr_addr);
  assign alua_alone    = alua_wr_en
                       && !(alub_wr_en && alub_wr_addr == alua_wr_addr)
                       && !(ctl_wr_en  && ctl_wr_addr  == alua_wr_addr)
                       && !(mem_wr_en  && mem_wr_addr  == alua_wr_addr);

  AST_SAME_ADDR_SAME_DATA: assert property (@(posedge clk) disable iff (rst)
    (alua_rs0_addr == ctl_ix_addr) |-> (alua_rs0_data == ctl_ix_data)); // R1

  AST_ALUA_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(alua_alone) && ctl_tst_addr == $past(alua_wr_addr))
      |-> (ctl_tst_data == $past(alua_wr_data))); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(any_wr) && $stable(ctl_ix_addr))
      |-> $stable(ctl_ix_data)); // R4

  AST_MEM_RANK_TOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mem_wr_en) && alua_rs0_addr == $past(mem_wr_addr))
      |-> (alua_rs0_data == $past(mem_wr_data))); // R5

  AST_CTL_OVER_ALU: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl_beats_mem) && mem_ix_addr == $past(ctl_wr_addr))
      |-> (mem_ix_data == $past(ctl_wr_data))); // R5

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (alua_rs0_data == '0 && alua_rs1_data == '0 &&
                    alub_rs0_data == '0 && alub_rs1_data == '0 &&
                    mem_sd_data   == '0 && mem_ix_data   == '0 &&
                    ctl_tst_data  == '0 && ctl_ix_data   == '0)); // R6
endmodule

bind vliw_regfile vrf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/vliw_regfile_tb.sv
module vliw_regfile_tb;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int NREG = 64;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] ra [8];
  logic [DW-1:0] rd [8];
  logic          we [4];   // 0 alua, 1 alub, 2 ctl, 3 mem (ascending rank)
  logic [AW-1:0] wa [4];
  logic [DW-1:0] wd [4];

  logic [DW-1:0] model [NREG];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vliw_regfile u_dut (
    .clk(clk), .rst(rst),
    .alua_rs0_addr(ra[0]), .alua_rs0_data(rd[0]),
    .alua_rs1_addr(ra[1]), .alua_rs1_data(rd[1]),
    .alub_rs0_addr(ra[2]), .alub_rs0_data(rd[2]),
    .alub_rs1_addr(ra[3]), .alub_rs1_data(rd[3]),
    .mem_sd_addr(ra[4]),   .mem_sd_data(rd[4]),
    .mem_ix_addr(ra[5]),   .mem_ix_data(rd[5]),
    .ctl_tst_addr(ra[6]),  .ctl_tst_data(rd[6]),
    .ctl_ix_addr(ra[7]),   .ctl_ix_data(rd[7]),
    .alua_wr_en(we[0]), .alua_wr_addr(wa[0]), .alua_wr_data(wd[0]),
    .alub_wr_en(we[1]), .alub_wr_addr(wa[1]), .alub_wr_data(wd[1]),
    .ctl_wr_en(we[2]),  .ctl_wr_addr(wa[2]),  .ctl_wr_data(wd[2]),
    .mem_wr_en(we[3]),  .mem_wr_addr(wa[3]),  .mem_wr_data(wd[3])
  );

  // Compare reads against the model, then let one edge pass and apply writes
  // to the model in ascending rank so the highest-ranked one stays.
  task automatic step(input string tag);
    #1;
    for (int i = 0; i < 8; i++) begin
      checks++;
      if (rd[i] !== model[ra[i]]) begin
        errors++;
        $display("FAIL %s read port %0d addr %0d actual %h expected %h",
                 tag, i, ra[i], rd[i], model[ra[i]]);
      end
    end
    @(posedge clk);
    if (rst) begin
      for (int r = 0; r < NREG; r++) model[r] = '0;
    end else begin
      for (int p = 0; p < 4; p++) if (we[p]) model[wa[p]] = wd[p];
    end
    @(negedge clk);
  endtask

  task automatic idle_writes();
    for (int p = 0; p < 4; p++) begin
      we[p] = 1'b0; wa[p] = AW'($urandom); wd[p] = $urandom;
    end
  endtask

  task automatic rand_reads(input bit narrow);
    for (int i = 0; i < 8; i++) ra[i] = narrow ? AW'($urandom % 8) : AW'($urandom);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = 'x;
    rst = 1'b1;
    idle_writes();
    rand_reads(1'b0);
    @(negedge clk);
    // R6: writes enabled while in reset must not stick
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 4; p++) begin we[p] = 1'b1; wa[p] = AW'(p); wd[p] = $urandom; end
      @(posedge clk);
      @(negedge clk);
    end
    for (int r = 0; r < NREG; r++) model[r] = '0;
    rst = 1'b0;
    idle_writes();
    // R6: sweep all registers, expect zero
    for (int blk = 0; blk < 8; blk++) begin
      for (int i = 0; i < 8; i++) ra[i] = AW'(blk * 8 + i);
      step("R6");
    end

    // R7 / R3: four distinct targets per cycle, fill the whole file
    for (int blk = 0; blk < 16; blk++) begin
      for (int p = 0; p < 4; p++) begin
        we[p] = 1'b1; wa[p] = AW'(blk * 4 + p); wd[p] = $urandom;
      end
      rand_reads(1'b0);
      step("R7");
    end
    idle_writes();
    for (int blk = 0; blk < 8; blk++) begin
      for (int i = 0; i < 8; i++) ra[i] = AW'(blk * 8 + i);
      step("R3");
    end

    // R2: read the registers being written in the same cycle
    for (int c = 0; c < 20; c++) begin
      for (int p = 0; p < 4; p++) begin
        we[p] = 1'b1; wa[p] = AW'($urandom); wd[p] = $urandom;
      end
      for (int i = 0; i < 8; i++) ra[i] = wa[i % 4];
      step("R2");
      idle_writes();
      for (int i = 0; i < 8; i++) ra[i] = wa[i % 4];
    end

    // R5: collisions over every non-empty subset of ports at one address
    for (int rep = 0; rep < 4; rep++) begin
      for (int mask = 1; mask < 16; mask++) begin
        logic [AW-1:0] tgt;
        tgt = AW'($urandom);
        for (int p = 0; p < 4; p++) begin
          we[p] = mask[p]; wa[p] = tgt; wd[p] = $urandom;
        end
        for (int i = 0; i < 8; i++) ra[i] = tgt;
        step("R5");
        idle_writes();
        for (int i = 0; i < 8; i++) ra[i] = tgt;
        step("R5");
      end
    end

    // R4: disabled ports with live address and data
    for (int c = 0; c < 40; c++) begin
      idle_writes();
      for (int i = 0; i < 8; i++) ra[i] = wa[i % 4];
      step("R4");
    end

    // R1: random traffic, half the time on a narrow address window
    for (int c = 0; c < 3000; c++) begin
      bit narrow;
      narrow = c[0];
      for (int p = 0; p < 4; p++) begin
        we[p] = ($urandom % 3) != 0;
        wa[p] = narrow ? AW'($urandom % 8) : AW'($urandom);
        wd[p] = $urandom;
      end
      rand_reads(narrow);
      step("R1");
    end

    // R6: reset mid-run with every write port enabled
    for (int p = 0; p < 4; p++) begin we[p] = 1'b1; wa[p] = AW'(p + 8); wd[p] = $urandom; end
    rst = 1'b1;
    rand_reads(1'b0);
    step("R6");
    rst = 1'b0;
    idle_writes();
    for (int blk = 0; blk < 8; blk++) begin
      for (int i = 0; i < 8; i++) ra[i] = AW'(blk * 8 + i);
      step("R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule